// File: doc/BRIEF.md
# Link Wake-Up Beacon Generator

This block raises a wake-up beacon for a link-layer controller that has gone to sleep. While the link counts as inactive, and at least one wake reason is pending, the block drives a square wave on its output. The link counts as inactive whenever the debounced power-status flag is low or the software link-control bit is clear. As soon as both are high, the beacon stops. When no reason is pending, the output is held low. During hardware reset the output is held low and a separate flag asks the pad logic to float the pin.

There are three kinds of wake reason. The first is a sticky request set by a link-on packet addressed to this node; a bus reset withdraws it. The second is a level taken from the interrupt status bits, which a bus reset cannot withdraw. If such an interrupt is pending while the link is active, the beacon starts as soon as the link drops. The third is a timed request set by a power-cycle event whose power class is 0 to 4; it lapses after a parameterised number of cycles.

Top module: `link_wake_gen`

## Requirements
- R1: While a wake reason is pending and the link is inactive, `wake_o` repeats a pattern of PERIOD cycles: PERIOD/2 cycles high, then PERIOD/2 cycles low.
- R2: Each new activation begins at phase zero, so its first PERIOD/2 cycles are high.
- R3: While `rst_n` is 0, `wake_hiz_o` is 1 and `wake_o` is 0. Out of reset, `wake_hiz_o` is 0, and `wake_o` is 0 whenever no reason is pending.
- R4: While `pwr_status_i` and `link_ctrl_i` are both 1, `wake_o` is 0 whatever the triggers. The packet and power-cycle requests are discarded in that state.
- R5: A one-cycle `pkt_wake_i` pulse, sampled while the link is inactive, activates `wake_o` from the next cycle and keeps it active until the link is active. A pulse sampled while the link is active is ignored.
- R6: While the link is inactive, `irq_port_evt_i` at 1 activates `wake_o` in the same cycle.
- R7: `irq_cfg_tmo_i`, `irq_cbl_pwr_i` or `irq_state_tmo_i` at 1 activates `wake_o` only while `irq_resume_en_i` is 1. With the enable at 0, these bits have no effect.
- R8: A `bus_reset_i` pulse withdraws the packet request, so `wake_o` is 0 from the next cycle if nothing else is pending. A qualifying interrupt keeps the wave running through the bus reset.
- R9: If a qualifying interrupt is held while the link is active, `wake_o` goes high in the same cycle the link becomes inactive.
- R10: A `pwr_cycle_i` pulse with `pwr_class_i` from 0 to 4 activates `wake_o` from the next cycle. Classes 5 to 7 are ignored.
- R11: A power-cycle request on its own keeps `wake_o` active for exactly PWR_TMO_CYC cycles after the cycle in which the pulse was sampled, then lets it fall to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| pwr_status_i | input | 1 | Debounced link power-status flag, 1 = active |
| link_ctrl_i | input | 1 | Software link-control bit |
| pkt_wake_i | input | 1 | Pulse: link-on packet for this node received |
| irq_port_evt_i | input | 1 | Port-event interrupt status |
| irq_cfg_tmo_i | input | 1 | Configuration-timeout interrupt status |
| irq_cbl_pwr_i | input | 1 | Cable-power-status interrupt status |
| irq_state_tmo_i | input | 1 | State-timeout interrupt status |
| irq_resume_en_i | input | 1 | Resuming-port interrupt enable |
| bus_reset_i | input | 1 | Pulse: bus reset occurred |
| pwr_cycle_i | input | 1 | Pulse: power-cycle event |
| pwr_class_i | input | 3 | Power class accompanying the power-cycle event |
| wake_o | output | 1 | Wake-up square wave |
| wake_hiz_o | output | 1 | Request to float the wake pin (during reset) |

## Verification
The bench builds the block with PERIOD = 6 and PWR_TMO_CYC = 20. A period of 6 is not a power of two, so it selects the phase-counter variant that wraps explicitly, and its odd half-period of 3 makes an off-by-one in the wrap visible. The short timeout places the whole life of a power-cycle request inside a few dozen sampled cycles. That lets the bench check the last active cycle and the first silent cycle exactly.

// File: rtl/wake_pkg.sv
package wake_pkg;

   typedef struct packed {
      logic port_evt;
      logic cfg_tmo;
      logic cbl_pwr;
      logic state_tmo;
      logic resume_en;
   } irq_bits_t;

   function automatic logic irq_qualifies(irq_bits_t b);
      return b.port_evt | (b.resume_en & (b.cfg_tmo | b.cbl_pwr | b.state_tmo));
   endfunction

endpackage

// File: rtl/wake_pkt_latch.sv
module wake_pkt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic link_up_i,
   input  logic pkt_i,
   input  logic bus_reset_i,
   output logic pkt_req_o
);

   logic pkt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pkt_q <= 1'b0;
      else if (link_up_i)   pkt_q <= 1'b0;
      else if (bus_reset_i) pkt_q <= 1'b0;
      else if (pkt_i)       pkt_q <= 1'b1;
   end

   assign pkt_req_o = pkt_q;

   assert_busrst_drops_pkt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> !pkt_req_o);

   assert_pkt_ignored_link_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      link_up_i |=> !pkt_req_o);

endmodule

// File: rtl/wake_pwr_timer.sv
module wake_pwr_timer #(
   parameter int CLASS_W     = 3,
   parameter int MAX_CLASS   = 4,
   parameter int PWR_TMO_CYC = 16417
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               link_up_i,
   input  logic               pwr_cycle_i,
   input  logic [CLASS_W-1:0] pwr_class_i,
   output logic               pwr_req_o
);

   localparam int CW = $clog2(PWR_TMO_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(PWR_TMO_CYC - 1);

   if (PWR_TMO_CYC < 1) begin : g_bad_tmo
      $error("PWR_TMO_CYC must be at least 1");
   end
   if (MAX_CLASS >= (1 << CLASS_W)) begin : g_bad_class
      $error("MAX_CLASS does not fit in CLASS_W bits");
   end

   logic          pwr_q;
   logic [CW-1:0] cnt_q;
   logic          qual;

   assign qual = pwr_cycle_i && (32'(pwr_class_i) <= MAX_CLASS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q <= 1'b0;
         cnt_q <= '0;
      end else if (link_up_i) begin
         pwr_q <= 1'b0;
         cnt_q <= '0;
      end else if (qual) begin
         pwr_q <= 1'b1;
         cnt_q <= '0;
      end else if (pwr_q) begin
         if (cnt_q == LAST) begin
            pwr_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pwr_req_o = pwr_q;

   assert_tmo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_q |-> (32'(cnt_q) < PWR_TMO_CYC));

   assert_class_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_q && (!pwr_cycle_i || 32'(pwr_class_i) > MAX_CLASS)) |=> !pwr_q);

endmodule

// File: rtl/wake_square_gen.sv
module wake_square_gen #(
   parameter int PERIOD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic wave_o
);

   localparam int PW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam int HALF = PERIOD / 2;
   localparam logic [PW-1:0] HALF_V = PW'(HALF);
   localparam logic [PW-1:0] LAST_V = PW'(PERIOD - 1);
   localparam bit   POW2 = ((PERIOD & (PERIOD - 1)) == 0);

   if (PERIOD < 2 || (PERIOD % 2) != 0) begin : g_bad_period
      $error("PERIOD must be even and at least 2");
   end

   logic [PW-1:0] phase_q;
   logic          prev_act_q;

   if (POW2) begin : g_wrap_free
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        phase_q <= '0;
         else if (active_i) phase_q <= phase_q + 1'b1;
         else               phase_q <= '0;
      end
   end else begin : g_wrap_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 phase_q <= '0;
         else if (!active_i)         phase_q <= '0;
         else if (phase_q == LAST_V) phase_q <= '0;
         else                        phase_q <= phase_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_act_q <= 1'b0;
      else        prev_act_q <= active_i;
   end

   assign wave_o = active_i && (phase_q < HALF_V);

   assert_first_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !prev_act_q) |-> wave_o);

   assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |-> !wave_o);

   assert_fall_mid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && prev_act_q && phase_q == HALF_V) |-> (!wave_o && $past(wave_o)));

   assert_rise_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && prev_act_q && phase_q == '0) |-> (wave_o && !$past(wave_o)));

endmodule

// File: rtl/link_wake_gen.sv
module link_wake_gen #(
   parameter int PERIOD      = 8,
   parameter int PWR_TMO_CYC = 16417,
   parameter int CLASS_W     = 3,
   parameter int MAX_CLASS   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_status_i,
   input  logic               link_ctrl_i,
   input  logic               pkt_wake_i,
   input  logic               irq_port_evt_i,
   input  logic               irq_cfg_tmo_i,
   input  logic               irq_cbl_pwr_i,
   input  logic               irq_state_tmo_i,
   input  logic               irq_resume_en_i,
   input  logic               bus_reset_i,
   input  logic               pwr_cycle_i,
   input  logic [CLASS_W-1:0] pwr_class_i,
   output logic               wake_o,
   output logic               wake_hiz_o
);

   import wake_pkg::*;

   logic      link_up;
   logic      pkt_req;
   logic      pwr_req;
   logic      irq_req;
   logic      active;
   irq_bits_t irq_bits;

   assign link_up  = pwr_status_i & link_ctrl_i;
   assign irq_bits = '{port_evt:  irq_port_evt_i,
                       cfg_tmo:   irq_cfg_tmo_i,
                       cbl_pwr:   irq_cbl_pwr_i,
                       state_tmo: irq_state_tmo_i,
                       resume_en: irq_resume_en_i};
   assign irq_req  = irq_qualifies(irq_bits);
   assign active   = rst_n & ~link_up & (pkt_req | pwr_req | irq_req);

   wake_pkt_latch u_pkt (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_up_i   (link_up),
      .pkt_i       (pkt_wake_i),
      .bus_reset_i (bus_reset_i),
      .pkt_req_o   (pkt_req)
   );

   wake_pwr_timer #(
      .CLASS_W     (CLASS_W),
      .MAX_CLASS   (MAX_CLASS),
      .PWR_TMO_CYC (PWR_TMO_CYC)
   ) u_pwr (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_up_i   (link_up),
      .pwr_cycle_i (pwr_cycle_i),
      .pwr_class_i (pwr_class_i),
      .pwr_req_o   (pwr_req)
   );

   wake_square_gen #(
      .PERIOD (PERIOD)
   ) u_sq (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .wave_o   (wake_o)
   );

   assign wake_hiz_o = ~rst_n;

   always_comb begin
      if (!rst_n) begin
         assert_hiz_in_reset_R3: assert (wake_hiz_o && !wake_o);
      end
   end

   assert_link_up_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |-> !wake_o);

   assert_irq_keeps_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && irq_port_evt_i) |-> active);

   assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_resume_en_i && !irq_port_evt_i && !pkt_req && !pwr_req) |-> !wake_o);

endmodule

// File: tb/link_wake_gen_bench.sv
module link_wake_gen_bench;

   localparam int PER  = 6;
   localparam int HALF = PER / 2;
   localparam int TMO  = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_status = 1'b0, link_ctrl = 1'b1, pkt = 1'b0;
   logic       i_pe = 1'b0, i_cfg = 1'b0, i_cbl = 1'b0, i_st = 1'b0, i_en = 1'b0;
   logic       brst = 1'b0, pcyc = 1'b0;
   logic [2:0] pclass = 3'd0;
   logic       wake, hiz;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   link_wake_gen #(.PERIOD(PER), .PWR_TMO_CYC(TMO)) u_link_wake_gen (
      .clk(clk), .rst_n(rst_n), .pwr_status_i(pwr_status), .link_ctrl_i(link_ctrl),
      .pkt_wake_i(pkt), .irq_port_evt_i(i_pe), .irq_cfg_tmo_i(i_cfg),
      .irq_cbl_pwr_i(i_cbl), .irq_state_tmo_i(i_st), .irq_resume_en_i(i_en),
      .bus_reset_i(brst), .pwr_cycle_i(pcyc), .pwr_class_i(pclass),
      .wake_o(wake), .wake_hiz_o(hiz)
   );

   // bits: [5] port_evt [4] cfg [3] cbl [2] state [1] resume_en [0] expected
   localparam logic [5:0] IRQ_VEC [10] = '{
      6'b000000, 6'b100001, 6'b010000, 6'b001000, 6'b000100,
      6'b000010, 6'b010011, 6'b001011, 6'b000111, 6'b111101
   };

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic edge_step();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_all();
      {i_pe, i_cfg, i_cbl, i_st, i_en, pkt, brst, pcyc} = '0;
   endtask

   task automatic wake_link();
      pwr_status = 1'b1;
      link_ctrl  = 1'b1;
      edge_step();
      edge_step();
   endtask

   task automatic sleep_link();
      pwr_status = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      // R3 reset state
      i_pe = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R3 hiz in reset", hiz, 1'b1);
      chk("R3 wake low in reset", wake, 1'b0);
      i_pe = 1'b0;
      #1;
      rst_n = 1'b1;
      edge_step();
      @(negedge clk);
      chk("R3 hiz after reset", hiz, 1'b0);
      chk("R3 idle low", wake, 1'b0);

      // R6 R7 vector table, link inactive
      foreach (IRQ_VEC[i]) begin
         edge_step();
         {i_pe, i_cfg, i_cbl, i_st, i_en} = IRQ_VEC[i][5:1];
         @(negedge clk);
         chk($sformatf("R6/R7 vec %0d", i), wake, IRQ_VEC[i][0]);
         edge_step();
         clear_all();
         edge_step();
      end

      // R1 R2 square wave
      edge_step();
      i_pe = 1'b1;
      for (int k = 0; k < 2 * PER; k++) begin
         @(negedge clk);
         chk($sformatf("R1/R2 wave k=%0d", k), wake, (k % PER) < HALF);
      end

      // R4 link active silences, R9 rearm on link drop
      edge_step();
      wake_link();
      @(negedge clk);
      chk("R4 link up quiet", wake, 1'b0);
      edge_step();
      sleep_link();
      for (int k = 0; k < PER; k++) begin
         @(negedge clk);
         chk($sformatf("R9 rearm k=%0d", k), wake, (k % PER) < HALF);
      end
      edge_step();
      clear_all();
      edge_step();

      // R5 packet request
      pkt = 1'b1;
      edge_step();
      pkt = 1'b0;
      for (int k = 0; k < PER + 2; k++) begin
         @(negedge clk);
         chk($sformatf("R5 pkt wave k=%0d", k), wake, (k % PER) < HALF);
      end
      edge_step();
      wake_link();
      sleep_link();
      edge_step();
      @(negedge clk);
      chk("R4 pkt request discarded", wake, 1'b0);
      pwr_status = 1'b1;
      edge_step();
      pkt = 1'b1;
      edge_step();
      pkt = 1'b0;
      sleep_link();
      edge_step();
      @(negedge clk);
      chk("R5 pkt ignored while link up", wake, 1'b0);

      // R8 bus reset
      edge_step();
      pkt = 1'b1;
      edge_step();
      pkt = 1'b0;
      brst = 1'b1;
      edge_step();
      brst = 1'b0;
      @(negedge clk);
      chk("R8 bus reset drops pkt", wake, 1'b0);
      edge_step();
      pkt = 1'b1;
      i_pe = 1'b1;
      edge_step();
      pkt = 1'b0;
      brst = 1'b1;
      edge_step();
      brst = 1'b0;
      begin
         int highs = 0;
         for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            highs += int'(wake);
         end
         chk("R8 irq survives bus reset", highs == HALF, 1'b1);
      end
      edge_step();
      clear_all();
      edge_step();
      edge_step();

      // R10 R11 power cycle
      pclass = 3'd6;
      pcyc = 1'b1;
      edge_step();
      pcyc = 1'b0;
      @(negedge clk);
      chk("R10 class 6 ignored", wake, 1'b0);
      edge_step();
      pclass = 3'd4;
      pcyc = 1'b1;
      edge_step();
      pcyc = 1'b0;
      for (int k = 0; k < TMO + 4; k++) begin
         @(negedge clk);
         chk($sformatf("R10/R11 pwr k=%0d", k), wake, (k < TMO) && ((k % PER) < HALF));
      end

      finish_run();
   end

endmodule